// File: doc/BRIEF.md
# Dual-I/O Read Flash Responder

This block is the flash side of a serial link. It answers the dual-I/O read-array transaction. A controller lowers chip select and sends a one-byte command on data line 0. It then sends a 24-bit start address and an 8-bit mode byte, two bits per serial clock. The responder then streams bytes back, two bits per serial clock, from a 512 KB address space. The space is backed by a small on-chip byte array, and addresses outside that array return a computed fill value. The array is preloaded at reset from an arithmetic pattern, and a plain write port can overwrite it.

Chip select, serial clock and the two data lines are oversampled by the block clock in SPI mode 0. Inputs are taken on rising serial-clock edges and outputs change on falling edges. The mode byte can arm a continuous-read state. In that state the next transaction starts with the address and sends no command byte. A mode value that does not arm the state clears it. Raising chip select at any point ends the read and puts both data lines back to high impedance. A command byte that is not recognised makes the block stay quiet until chip select rises.

Top module: `dual_read_flash_resp`

## Requirements
- R1: After reset, and while chip select is high, `io_oe_o` is 00.
- R2: The first eight rising serial-clock edges of a normal transaction shift in the command byte from `io_i[0]`, MSB first. Only the value BBh (parameter `OPCODE`) starts a read.
- R3: The address takes the next 12 rising edges, two bits per edge. The higher-order bit of each pair is on `io_i[1]`, so A23 arrives on `io_i[1]` and A22 on `io_i[0]` first.
- R4: The mode byte takes the next 4 rising edges, with M7 on `io_i[1]` and M6 on `io_i[0]` first. The outputs stay disabled during the command, address and mode phases.
- R5: The first falling edge after the last mode bit drives D7 on `io_o[1]` and D6 on `io_o[0]` and turns on both enables together. Each later falling edge drives the next pair, MSB first, so one byte takes four edges. `io_o` changes only on falling edges.
- R6: The read pointer holds the low 19 address bits, so address bits 23..19 are ignored. It steps by one per byte and rolls from 07FFFFh to 000000h with no gap in the stream.
- R7: When bits M5,M4 of the mode byte are 10, the next transaction begins with the address phase at its first rising edge.
- R8: Any other M5,M4 value clears continuous read, so the next transaction expects a command byte.
- R9: When chip select rises, even mid-byte, both enables return to 00, and the next transaction starts cleanly.
- R10: After an unrecognised command byte, `io_oe_o` stays 00 until chip select rises.
- R11: Addresses below `MEM_DEPTH` (256) read the array. Its reset content at index i is (37*i + 11) mod 256, and `wr_en_i` writes `wr_data_i` at `wr_addr_i` on a clock edge. Any other address a returns a[7:0] XOR a[15:8] XOR a[18:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock that oversamples the serial link |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, idle low |
| io_i | input | 2 | Sampled data lines (bit 1 carries the higher bit of each pair) |
| io_o | output | 2 | Driven data bits |
| io_oe_o | output | 2 | Output enables for the two data lines |
| wr_en_i | input | 1 | Array write strobe |
| wr_addr_i | input | 8 | Array write index |
| wr_data_i | input | 8 | Array write byte |

## Verification
Two things can happen on the same clock cycle: the byte fetch at a falling serial-clock edge and the 19-bit read pointer rolling from its top value to zero. The bench provokes this by starting reads just below 07FFFFh, once with the unused upper address bits set. It judges the result byte by byte. The stream must run through the computed fill values and then continue straight into array location 0, whose preload value 0Bh differs from what a pointer that failed to roll over would return.

// File: rtl/flash_resp_pkg.sv
package flash_resp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_MODE,
    ST_DATA,
    ST_IGN
  } resp_st_e;
endpackage

// File: rtl/flash_in_sync.sv
module flash_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_i,
  input  logic [1:0] io_i,
  output logic       cs_hi_o,
  output logic       rise_o,
  output logic       fall_o,
  output logic [1:0] io_o
);
  logic [STAGES-1:0] cs_p;
  logic [STAGES-1:0] sck_p;
  logic [1:0]        io_p [STAGES];
  logic              sck_prev;
  logic              sck_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_p     <= '1;
      sck_p    <= '0;
      sck_prev <= 1'b0;
      for (int i = 0; i < STAGES; i++) io_p[i] <= '0;
    end else begin
      cs_p[0]  <= cs_ni;
      sck_p[0] <= sck_i;
      io_p[0]  <= io_i;
      for (int i = 1; i < STAGES; i++) begin
        cs_p[i]  <= cs_p[i-1];
        sck_p[i] <= sck_p[i-1];
        io_p[i]  <= io_p[i-1];
      end
      sck_prev <= sck_s;
    end
  end

  assign sck_s   = sck_p[STAGES-1];
  assign cs_hi_o = cs_p[STAGES-1];
  assign io_o    = io_p[STAGES-1];
  // edges only count inside a selected transaction
  assign rise_o  = sck_s & ~sck_prev & ~cs_hi_o;
  assign fall_o  = ~sck_s & sck_prev & ~cs_hi_o;
endmodule

// File: rtl/flash_mem.sv
module flash_mem #(
  parameter int unsigned MEM_DEPTH   = 256,
  parameter int unsigned ARRAY_AW    = 19,
  parameter int unsigned PRELOAD_MUL = 37,
  parameter int unsigned PRELOAD_ADD = 11,
  localparam int unsigned MEM_AW     = $clog2(MEM_DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [MEM_AW-1:0]   wr_addr_i,
  input  logic [7:0]          wr_data_i,
  input  logic [ARRAY_AW-1:0] rd_addr_i,
  output logic [7:0]          rd_data_o
);
  localparam int unsigned NBYTES = (ARRAY_AW + 7) / 8;

  logic [7:0]          mem_q [MEM_DEPTH];
  logic [NBYTES*8-1:0] ext_addr;
  logic [7:0]          fill;
  logic                in_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= 8'(i * PRELOAD_MUL + PRELOAD_ADD);
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  // unbacked space: xor-fold of the address bytes
  always_comb begin
    ext_addr = (NBYTES*8)'(rd_addr_i);
    fill     = '0;
    for (int k = 0; k < NBYTES; k++) fill = fill ^ ext_addr[k*8 +: 8];
  end

  assign in_win    = rd_addr_i < ARRAY_AW'(MEM_DEPTH);
  assign rd_data_o = in_win ? mem_q[rd_addr_i[MEM_AW-1:0]] : fill;
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_resp_pkg::*;
#(
  parameter logic [7:0]  OPCODE   = 8'hBB,
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned ARRAY_AW = 19
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_hi_i,
  input  logic                rise_i,
  input  logic                fall_i,
  input  logic [1:0]          io_i,
  input  logic [7:0]          rd_data_i,
  output logic [ARRAY_AW-1:0] rd_addr_o,
  output logic                fetch_o,
  output resp_st_e            st_o,
  output logic [1:0]          io_o,
  output logic [1:0]          io_oe_o
);
  localparam int unsigned ADDR_CLKS = ADDR_W / 2;
  localparam int unsigned CNT_W     = $clog2(ADDR_CLKS + 1);
  typedef logic [ARRAY_AW-1:0] addr_t;

  resp_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [6:0]       op_sh;
  logic [7:0]       op_nx;
  addr_t            addr_sh;
  addr_t            rd_addr_q;
  logic             mode_hit_q;
  logic             cont_q;
  logic [1:0]       phase_q;
  logic [5:0]       sh_q;
  logic [1:0]       io_q;
  logic             oe_q;

  assign op_nx = {op_sh, io_i[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      op_sh      <= '0;
      addr_sh    <= '0;
      rd_addr_q  <= '0;
      mode_hit_q <= 1'b0;
      cont_q     <= 1'b0;
      phase_q    <= '0;
      sh_q       <= '0;
      io_q       <= '0;
      oe_q       <= 1'b0;
    end else if (cs_hi_i) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      phase_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_q  <= cont_q ? ST_ADDR : ST_OPC;
          cnt_q <= '0;
        end
        ST_OPC: if (rise_i) begin
          op_sh <= op_nx[6:0];
          if (cnt_q == CNT_W'(7)) begin
            st_q  <= (op_nx == OPCODE) ? ST_ADDR : ST_IGN;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ADDR: if (rise_i) begin
          // upper address bits fall off the top of the pointer width
          addr_sh <= addr_t'({addr_sh, io_i});
          if (cnt_q == CNT_W'(ADDR_CLKS - 1)) begin
            st_q  <= ST_MODE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_MODE: if (rise_i) begin
          if (cnt_q == CNT_W'(1)) mode_hit_q <= (io_i == 2'b10);
          if (cnt_q == CNT_W'(3)) begin
            cont_q    <= mode_hit_q;
            rd_addr_q <= addr_sh;
            phase_q   <= '0;
            st_q      <= ST_DATA;
            cnt_q     <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: if (fall_i) begin
          phase_q <= phase_q + 1'b1;
          if (phase_q == 2'd0) begin
            io_q      <= rd_data_i[7:6];
            sh_q      <= rd_data_i[5:0];
            rd_addr_q <= rd_addr_q + 1'b1;
            oe_q      <= 1'b1;
          end else begin
            io_q <= sh_q[5:4];
            sh_q <= {sh_q[3:0], 2'b00};
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_addr_o = rd_addr_q;
  assign fetch_o   = (st_q == ST_DATA) && fall_i && (phase_q == 2'd0);
  assign st_o      = st_q;
  assign io_o      = io_q;
  assign io_oe_o   = {2{oe_q}};
endmodule

// File: rtl/dual_read_flash_resp.sv
module dual_read_flash_resp
  import flash_resp_pkg::*;
#(
  parameter logic [7:0]  OPCODE      = 8'hBB,
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned ARRAY_AW    = 19,
  parameter int unsigned MEM_DEPTH   = 256,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned MEM_AW     = $clog2(MEM_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic [1:0]        io_i,
  output logic [1:0]        io_o,
  output logic [1:0]        io_oe_o,
  input  logic              wr_en_i,
  input  logic [MEM_AW-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i
);
  logic                cs_hi_w;
  logic                rise_w;
  logic                fall_w;
  logic [1:0]          io_s_w;
  logic [7:0]          rd_data_w;
  logic [ARRAY_AW-1:0] rd_addr_w;
  logic                fetch_w;
  resp_st_e            st_w;

  flash_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .sck_i   (sck_i),
    .io_i    (io_i),
    .cs_hi_o (cs_hi_w),
    .rise_o  (rise_w),
    .fall_o  (fall_w),
    .io_o    (io_s_w)
  );

  flash_seq #(
    .OPCODE   (OPCODE),
    .ADDR_W   (ADDR_W),
    .ARRAY_AW (ARRAY_AW)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_hi_i   (cs_hi_w),
    .rise_i    (rise_w),
    .fall_i    (fall_w),
    .io_i      (io_s_w),
    .rd_data_i (rd_data_w),
    .rd_addr_o (rd_addr_w),
    .fetch_o   (fetch_w),
    .st_o      (st_w),
    .io_o      (io_o),
    .io_oe_o   (io_oe_o)
  );

  flash_mem #(
    .MEM_DEPTH (MEM_DEPTH),
    .ARRAY_AW  (ARRAY_AW)
  ) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_w),
    .rd_data_o (rd_data_w)
  );
endmodule

// File: rtl/flash_resp_chk.sv
module flash_resp_chk
  import flash_resp_pkg::*;
#(
  parameter int unsigned ARRAY_AW = 19
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cs_hi_i,
  input logic                fall_i,
  input logic                fetch_i,
  input resp_st_e            st_i,
  input logic [ARRAY_AW-1:0] rd_addr_i,
  input logic [1:0]          io_i,
  input logic [1:0]          oe_i
);
  AST_CS_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_hi_i |=> (oe_i == 2'b00)); // R9
  AST_OE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i == 2'b00) || (oe_i == 2'b11)); // R5
  AST_IO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(io_i)); // R5
  AST_HDR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_OPC || st_i == ST_ADDR || st_i == ST_MODE) |-> (oe_i == 2'b00)); // R4
  AST_IGN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IGN) |-> (oe_i == 2'b00)); // R10
  AST_ADDR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_i && rd_addr_i == '1) |=> (rd_addr_i == '0)); // R6
endmodule

bind dual_read_flash_resp flash_resp_chk #(.ARRAY_AW(ARRAY_AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_hi_i   (cs_hi_w),
  .fall_i    (fall_w),
  .fetch_i   (fetch_w),
  .st_i      (st_w),
  .rd_addr_i (rd_addr_w),
  .io_i      (io_o),
  .oe_i      (io_oe_o)
);

// File: tb/tb_dual_read_flash_resp.sv
module tb_dual_read_flash_resp;
  localparam time HALF = 64ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic [1:0] io_in = 2'b00;
  logic [1:0] io_out;
  logic [1:0] io_oe;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;

  int         n_tests = 0;
  int         n_fail = 0;
  bit         done = 1'b0;
  logic [7:0] model [256];

  always #4ns clk = ~clk;

  dual_read_flash_resp dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cs_ni     (cs_n),
    .sck_i     (sck),
    .io_i      (io_in),
    .io_o      (io_out),
    .io_oe_o   (io_oe),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data)
  );

  function automatic logic [7:0] exp_byte(input int unsigned a);
    int unsigned m = a & 32'h7FFFF;
    if (m < 256) return model[m];
    return 8'(m) ^ 8'(m >> 8) ^ 8'(m >> 16);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pair(input logic [1:0] d, output logic [1:0] q, output logic [1:0] oe);
    io_in = d;
    #(HALF);
    sck = 1'b1;
    #(HALF);
    q  = io_out;
    oe = io_oe;
    sck = 1'b0;
  endtask

  task automatic txn(input bit send_op, input logic [7:0] op, input logic [23:0] addr,
                     input logic [7:0] mode, input int nbytes, input int extra,
                     input string req);
    logic [1:0] q, oe;
    logic [7:0] byte_v;
    bit         hdr_quiet = 1'b1;
    bit         dat_on = 1'b1;
    bit         quiet = send_op && (op != 8'hBB);
    cs_n = 1'b0;
    #(HALF);
    if (send_op)
      for (int i = 7; i >= 0; i--) begin
        pair({1'b0, op[i]}, q, oe);
        if (oe != 2'b00) hdr_quiet = 1'b0;
      end
    if (!quiet) begin
      for (int i = 11; i >= 0; i--) begin
        pair(addr[2*i +: 2], q, oe);
        if (oe != 2'b00) hdr_quiet = 1'b0;
      end
      for (int i = 3; i >= 0; i--) begin
        pair(mode[2*i +: 2], q, oe);
        if (oe != 2'b00) hdr_quiet = 1'b0;
      end
      chk(hdr_quiet, "R4", "enables off in header", 1, 0);
      for (int b = 0; b < nbytes; b++) begin
        byte_v = '0;
        for (int k = 0; k < 4; k++) begin
          pair(2'b00, q, oe);
          byte_v = {byte_v[5:0], q};
          if (oe != 2'b11) dat_on = 1'b0;
        end
        chk(byte_v == exp_byte(int'(addr) + b), req, $sformatf("byte %0d @%06h", b, addr),
            byte_v, exp_byte(int'(addr) + b));
      end
      chk(dat_on, "R5", "enables on during data", 0, 3);
      for (int k = 0; k < extra; k++) pair(2'b00, q, oe);
    end else begin
      for (int k = 0; k < 40; k++) begin
        pair(2'b11, q, oe);
        if (oe != 2'b00) hdr_quiet = 1'b0;
      end
      chk(hdr_quiet, "R10", "quiet after unknown command", 1, 0);
    end
    cs_n = 1'b1;
    #(HALF * 4);
    chk(io_oe == 2'b00, "R9", "enables after chip select high", io_oe, 0);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'(i * 37 + 11);
    #40ns;
    rst_n = 1'b1;
    #(HALF);
    chk(io_oe == 2'b00, "R1", "enables after reset", io_oe, 0);

    // R2 R3 R4 R5 R11: plain read
    txn(1, 8'hBB, 24'h000010, 8'h00, 6, 0, "R3");
    // R6 R11: sweep of starts across window edge, fill space and top of array
    begin
      int starts [6] = '{32'h000000, 32'h000037, 32'h0000FE, 32'h012345,
                         32'h07FFFC, 32'hF7FFFE};
      foreach (starts[s]) txn(1, 8'hBB, 24'(starts[s]), 8'h00, 6, 0, "R6");
    end

    // R11: write port then read back
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'(8'h20 + i); wr_data = 8'(i * 13 + 8'h50);
      model[8'h20 + i] = 8'(i * 13 + 8'h50);
    end
    @(negedge clk);
    wr_en = 1'b0;
    #(HALF);
    txn(1, 8'hBB, 24'h00001E, 8'h00, 10, 0, "R11");

    // R7: arm continuous read, then two transactions without command byte
    txn(1, 8'hBB, 24'h000040, 8'h20, 3, 0, "R7");
    txn(0, 8'h00, 24'h000080, 8'hA5, 3, 0, "R7");
    txn(0, 8'h00, 24'h000123, 8'h00, 2, 0, "R7");
    // R8: cleared, command needed again; values 11 and 01 also clear
    txn(1, 8'hBB, 24'h000005, 8'hFF, 2, 0, "R8");
    txn(1, 8'hBB, 24'h000006, 8'h10, 2, 0, "R8");
    txn(1, 8'hBB, 24'h000007, 8'h00, 2, 0, "R8");

    // R9: abort mid-byte, then a clean read
    txn(1, 8'hBB, 24'h000090, 8'h00, 1, 2, "R9");
    txn(1, 8'hBB, 24'h0000A0, 8'h00, 3, 0, "R9");

    // R10 R2: unknown command, then normal read
    txn(1, 8'h03, 24'h000000, 8'h00, 0, 0, "R10");
    txn(1, 8'h6B, 24'h000000, 8'h00, 0, 0, "R2");
    txn(1, 8'hBB, 24'h000011, 8'h00, 2, 0, "R2");

    chk(io_oe == 2'b00, "R1", "enables while deselected", io_oe, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule